// File: doc/BRIEF.md
# Page-translated DMA engine

This block moves a run of bytes between a peripheral and system memory on behalf of one of four channels. Software programs each channel with a logical start address, a byte budget and a mode word holding the enable and direction bits. It also sets one global pair: where the translation table sits in memory and how many bytes of it are valid. A peripheral then asks for a transfer by naming a channel, a direction and a length.

The engine first checks that the channel is enabled and points the same way as the request. It then walks the logical address one 4096-byte page at a time. For every page it reads the page's frame address from the in-memory table and then moves the bytes of that page to or from the translated location. When it stops, it leaves a terminal-count or memory-error flag in the channel's mode word. One request is handled at a time. The memory master port carries both the table fetches and the data bytes. Bytes bound for the peripheral leave on a transmit strobe. Bytes from the peripheral arrive on a valid/ready pair.

Top module: `pgdma_engine`

## Requirements
- R1: After reset every channel's mode, count and logical address registers, the table base and the table limit all read zero, and busy is low.
- R2: Register address bit 4 clear selects a channel register: bits 3:2 give the channel and bits 1:0 the field (0 mode, 1 remaining count, 2 logical address). Bit 4 set selects a global register: bits 1:0 = 0 for the table base, 1 for the table limit. A write to an address is read back unchanged.
- R3: Mode bit 8 (terminal count), bit 9 (memory error) and bit 10 (address error) are cleared when a request is accepted.
- R4: Mode bit 0 enables the channel. Mode bit 1 set means memory-to-device and clear means device-to-memory. If the channel is disabled, or bit 1 differs from `req_to_dev`, the engine sets bit 9, makes no memory or device access, and leaves the count and address unchanged.
- R5: The request length is clamped to the channel's remaining count. At the end, the count has dropped and the logical address has risen by exactly the number of bytes moved.
- R6: For each page touched, the engine first reads the table entry at (table base + (logical address >> 12) * 8) with bit 31 cleared. It uses that 32-bit word as the frame address and ignores the entry's second word.
- R7: Each data byte goes to the frame address plus the low 12 bits of its logical address. Crossing a 4096-byte logical boundary triggers a fresh table read.
- R8: If a page index is at or above (table limit >> 3), the engine sets bit 9 and stops before that page; bytes already moved from earlier pages stay counted.
- R9: When every clamped byte has been moved, bit 8 is set. A request of length zero sets bit 8 at once, with no memory access.
- R10: A memory-to-device request reads each byte from memory and presents it for one cycle on `dev_tx_valid`/`dev_tx_data`. A device-to-memory request takes each byte when `dev_rx_valid` and `dev_rx_ready` are both high and writes it to memory, in logical address order.
- R11: `busy` is high from the cycle after a request is accepted until the engine returns to idle. `done` pulses for exactly one cycle per accepted request. Requests presented while busy are ignored.
- R12: Register writes presented while busy are ignored.
- R13: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Transfer request strobe |
| req_ch | input | 2 | Channel of the request |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | 16 | Requested byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data (table word, or byte in bits 7:0) |
| dev_tx_valid | output | 1 | Byte for the peripheral is valid |
| dev_tx_data | output | 8 | Byte for the peripheral |
| dev_rx_ready | output | 1 | Engine can take a peripheral byte |
| dev_rx_valid | input | 1 | Peripheral byte is valid |
| dev_rx_data | input | 8 | Byte from the peripheral |

## Verification
The hardest situation to reach is a transfer that runs off the end of the translation table partway through. The first page must succeed, and the error must land exactly at the next page boundary. The stimulus places a channel's logical address six bytes below the last valid page's end, with a length that runs past it. The count and address must then show exactly the six bytes moved, alongside the error flag. A similar effort goes into proving that a stray request and a register write arriving mid-transfer change nothing. The bench aims these at a channel that was enabled and loaded beforehand, so a wrongly accepted request would show up as memory traffic or changed registers.

// File: rtl/pgdma_engine.sv
module pgdma_engine #(
  parameter int NCH = 4,
  parameter int LEN_W = 16,
  parameter int PAGE_BITS = 12,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [CHW-1:0]   req_ch,
  input  logic             req_to_dev,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             dev_tx_valid,
  output logic [7:0]       dev_tx_data,
  output logic             dev_rx_ready,
  input  logic             dev_rx_valid,
  input  logic [7:0]       dev_rx_data
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_PAGE, S_TBL, S_RD, S_DEVW, S_WR, S_FIN} st_t;

  localparam logic [31:0] F_TC   = 32'h0000_0100;
  localparam logic [31:0] F_MERR = 32'h0000_0200;
  localparam logic [31:0] F_CLR  = 32'h0000_0700;
  localparam logic [31:0] PMASK  = (32'd1 << PAGE_BITS) - 32'd1;

  st_t state;
  logic [31:0] mode_q [NCH];
  logic [31:0] cnt_q  [NCH];
  logic [31:0] addr_q [NCH];
  logic [31:0] base_q, lim_q, rem_q, frame_q;
  logic [CHW-1:0] ch_q;
  logic dir_q, tx_valid_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0] byte_q, tx_data_q;

  wire [31:0] cur_mode   = mode_q[ch_q];
  wire [31:0] cur_cnt    = cnt_q[ch_q];
  wire [31:0] cur_addr   = addr_q[ch_q];
  wire [31:0] page_idx   = cur_addr >> PAGE_BITS;
  wire [31:0] entry_addr = (base_q + (page_idx << 3)) & 32'h7FFF_FFFF;
  wire [31:0] phys_addr  = frame_q + (cur_addr & PMASK);
  wire [31:0] len32      = 32'(len_q);
  wire [31:0] clamped    = (len32 < cur_cnt) ? len32 : cur_cnt;
  wire        piece_end  = (rem_q == 32'd1) || ((cur_addr & PMASK) == PMASK);
  wire        bad_chan   = !cur_mode[0] || (cur_mode[1] != dir_q);
  wire [CHW-1:0] rsel    = reg_addr[RAW-2:2];
  wire st_t   after_byte = piece_end ? S_PAGE : (dir_q ? S_RD : S_DEVW);

  assign busy         = state != S_IDLE;
  assign done         = state == S_FIN;
  assign mem_req      = (state == S_TBL) || (state == S_RD) || (state == S_WR);
  assign mem_we       = state == S_WR;
  assign mem_addr     = (state == S_TBL) ? entry_addr : phys_addr;
  assign mem_wdata    = byte_q;
  assign dev_rx_ready = state == S_DEVW;
  assign dev_tx_valid = tx_valid_q;
  assign dev_tx_data  = tx_data_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[RAW-1]) begin
      if (reg_addr[1:0] == 2'd0) reg_rdata = base_q;
      else if (reg_addr[1:0] == 2'd1) reg_rdata = lim_q;
    end else begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = mode_q[rsel];
        2'd1: reg_rdata = cnt_q[rsel];
        2'd2: reg_rdata = addr_q[rsel];
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        cnt_q[i]  <= '0;
        addr_q[i] <= '0;
      end
      base_q <= '0; lim_q <= '0; rem_q <= '0; frame_q <= '0;
      ch_q <= '0; dir_q <= 1'b0; len_q <= '0; byte_q <= '0;
      tx_valid_q <= 1'b0; tx_data_q <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reg_wr) begin
            if (reg_addr[RAW-1]) begin
              if (reg_addr[1:0] == 2'd0) base_q <= reg_wdata;
              else if (reg_addr[1:0] == 2'd1) lim_q <= reg_wdata;
            end else begin
              case (reg_addr[1:0])
                2'd0: mode_q[rsel] <= reg_wdata;
                2'd1: cnt_q[rsel]  <= reg_wdata;
                2'd2: addr_q[rsel] <= reg_wdata;
                default: ;
              endcase
            end
          end
          if (req_valid) begin
            ch_q  <= req_ch;
            dir_q <= req_to_dev;
            len_q <= req_len;
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (bad_chan) begin
            mode_q[ch_q] <= (cur_mode & ~F_CLR) | F_MERR;
            state <= S_FIN;
          end else begin
            mode_q[ch_q] <= cur_mode & ~F_CLR;
            rem_q <= clamped;
            state <= S_PAGE;
          end
        end
        S_PAGE: begin
          if (rem_q == 32'd0) begin
            mode_q[ch_q] <= cur_mode | F_TC;
            state <= S_FIN;
          end else if (page_idx >= (lim_q >> 3)) begin
            mode_q[ch_q] <= cur_mode | F_MERR;
            state <= S_FIN;
          end else begin
            state <= S_TBL;
          end
        end
        S_TBL: if (mem_ack) begin
          frame_q <= mem_rdata;
          state <= dir_q ? S_RD : S_DEVW;
        end
        S_DEVW: if (dev_rx_valid) begin
          byte_q <= dev_rx_data;
          state <= S_WR;
        end
        S_RD, S_WR: if (mem_ack) begin
          if (state == S_RD) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= mem_rdata[7:0];
          end
          cnt_q[ch_q]  <= cur_cnt - 32'd1;
          addr_q[ch_q] <= cur_addr + 32'd1;
          rem_q <= rem_q - 32'd1;
          state <= after_byte;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HANDSHAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_ENTRY_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TBL) |-> !mem_addr[31] && !mem_we); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dev_rx_ready); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11
  AST_TX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid |-> dir_q && cur_mode[1]); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) && mem_ack |=> cnt_q[ch_q] == $past(cur_cnt) - 32'd1); // R5
  AST_NO_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q) && $stable(lim_q)); // R12

endmodule

// File: tb/sim_pgdma_engine.sv
`timescale 1ns/1ps
module sim_pgdma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic reg_wr = 0; logic [4:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0; logic [1:0] req_ch = 0; logic req_to_dev = 0; logic [15:0] req_len = 0;
  logic busy, done, mem_req, mem_we, mem_ack = 0; logic [31:0] mem_addr, mem_rdata = 0;
  logic [7:0] mem_wdata, dev_tx_data, dev_rx_data = 0;
  logic dev_tx_valid, dev_rx_ready, dev_rx_valid = 0;

  pgdma_engine u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ch(req_ch),
    .req_to_dev(req_to_dev), .req_len(req_len), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
    .dev_rx_ready(dev_rx_ready), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data));

  int n_tests = 0, n_fail = 0, done_cnt = 0, wait_cnt = 0;
  bit done_prev = 0;
  int unsigned rng = 32'd7;
  logic [7:0] mem [int unsigned];
  logic [41:0] exp_mem[$];   // {table, we, addr, data}
  logic [7:0] exp_tx[$], rx_src[$];
  logic [31:0] m_mode[4], m_cnt[4], m_addr[4], m_base, m_lim;
  logic [7:0] rx_seed = 8'h40;

  function automatic int unsigned rnd();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng >> 16;
  endfunction
  function automatic logic [7:0] rd8(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
  endfunction
  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory responder, compared against the model's expected access list
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 0;
    else if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        if (exp_mem.size() == 0) chk(0, "R4", "unexpected memory access", mem_addr, 0);
        else begin
          logic [41:0] e;
          e = exp_mem.pop_front();
          chk(mem_we == e[40], e[41] ? "R6" : "R10", "access direction", 32'(mem_we), 32'(e[40]));
          chk(mem_addr == e[39:8], e[41] ? "R6" : "R7", "access address", mem_addr, e[39:8]);
          if (e[40]) chk(mem_wdata == e[7:0], "R10", "write byte", 32'(mem_wdata), 32'(e[7:0]));
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata = mem_we ? 32'd0 : rd32(mem_addr);
        mem_ack = 1;
        wait_cnt = rnd() % 3;
      end
    end
  end

  always @(negedge clk) begin
    if (dev_rx_valid) dev_rx_valid = 0;
    else if (rst_n && dev_rx_ready && (rnd() % 2 == 0)) begin
      if (rx_src.size() == 0) chk(0, "R10", "unexpected rx ready", 1, 0);
      else begin dev_rx_data = rx_src.pop_front(); dev_rx_valid = 1; end
    end
    if (rst_n && dev_tx_valid) begin
      if (exp_tx.size() == 0) chk(0, "R10", "unexpected tx byte", 32'(dev_tx_data), 0);
      else begin
        logic [7:0] t;
        t = exp_tx.pop_front();
        chk(dev_tx_data == t, "R10", "tx byte", 32'(dev_tx_data), 32'(t));
      end
    end
    if (rst_n && done) begin
      done_cnt++;
      chk(!done_prev, "R11", "done wider than one cycle", 1, 0);
    end
    done_prev = done;
  end

  task automatic model_req(input int ch, input bit to_dev, input logic [31:0] len_in);
    logic [31:0] len, a, ncpy, idx, ent, fr, i;
    len = len_in;
    m_mode[ch] &= ~32'h700;
    if (!m_mode[ch][0] || (m_mode[ch][1] != to_dev)) begin m_mode[ch] |= 32'h200; return; end
    if (len > m_cnt[ch]) len = m_cnt[ch];
    a = m_addr[ch]; i = 0;
    forever begin
      if (i == len) begin m_mode[ch] |= 32'h100; break; end
      ncpy = 32'd4096 - (a & 32'hFFF);
      if (ncpy > len - i) ncpy = len - i;
      idx = a >> 12;
      if (idx >= (m_lim >> 3)) begin m_mode[ch] |= 32'h200; break; end
      ent = (m_base + idx * 8) & 32'h7FFF_FFFF;
      exp_mem.push_back({1'b1, 1'b0, ent, 8'h00});
      fr = rd32(ent);
      for (logic [31:0] k = 0; k < ncpy; k++) begin
        logic [31:0] ph;
        ph = fr + ((a + k) & 32'hFFF);
        if (to_dev) begin
          exp_mem.push_back({1'b0, 1'b0, ph, 8'h00});
          exp_tx.push_back(rd8(ph));
        end else begin
          rx_seed = rx_seed * 8'd5 + 8'd3;
          rx_src.push_back(rx_seed);
          exp_mem.push_back({1'b0, 1'b1, ph, rx_seed});
        end
      end
      i += ncpy; a += ncpy; m_cnt[ch] -= ncpy;
    end
    m_addr[ch] = a;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic set_ch(input int ch, input logic [31:0] md, input logic [31:0] ct, input logic [31:0] ad);
    reg_write({1'b0, 2'(ch), 2'd0}, md); m_mode[ch] = md;
    reg_write({1'b0, 2'(ch), 2'd1}, ct); m_cnt[ch] = ct;
    reg_write({1'b0, 2'(ch), 2'd2}, ad); m_addr[ch] = ad;
  endtask
  task automatic check_regs(input string tag);
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      reg_read({1'b0, 2'(c), 2'd0}, v); chk(v == m_mode[c], tag, "mode register", v, m_mode[c]);
      reg_read({1'b0, 2'(c), 2'd1}, v); chk(v == m_cnt[c],  tag, "count register", v, m_cnt[c]);
      reg_read({1'b0, 2'(c), 2'd2}, v); chk(v == m_addr[c], tag, "address register", v, m_addr[c]);
    end
  endtask
  task automatic start_req(input int ch, input bit td, input logic [15:0] len);
    model_req(ch, td, 32'(len));
    @(negedge clk); req_valid = 1; req_ch = 2'(ch); req_to_dev = td; req_len = len;
    @(negedge clk); req_valid = 0;
    chk(busy == 1, "R11", "busy after accept", 32'(busy), 1);
  endtask
  task automatic finish_req(input int d0, input string tag);
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R11", "done pulses", done_cnt, d0 + 1);
    chk(busy == 0, "R11", "idle after done", 32'(busy), 0);
    chk(exp_mem.size() == 0, tag, "memory accesses left", exp_mem.size(), 0);
    chk(exp_tx.size() == 0, "R10", "tx bytes left", exp_tx.size(), 0);
    check_regs(tag);
  endtask
  task automatic run_req(input int ch, input bit td, input logic [15:0] len, input string tag);
    int d0;
    d0 = done_cnt;
    start_req(ch, td, len);
    finish_req(d0, tag);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired: actual=busy expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int d0;
    for (int c = 0; c < 4; c++) begin m_mode[c] = 0; m_cnt[c] = 0; m_addr[c] = 0; end
    m_base = 0; m_lim = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_regs("R1");
    reg_read(5'h10, v); chk(v == 0, "R1", "table base", v, 0);
    reg_read(5'h11, v); chk(v == 0, "R1", "table limit", v, 0);
    chk(busy == 0, "R1", "busy", 32'(busy), 0);
    // R2 globals; base has bit 31 set so entry fetches must clear it (R6)
    reg_write(5'h10, 32'h8000_2000); m_base = 32'h8000_2000;
    reg_write(5'h11, 32'd128);       m_lim = 32'd128;
    reg_read(5'h10, v); chk(v == m_base, "R2", "table base readback", v, m_base);
    reg_read(5'h11, v); chk(v == m_lim, "R2", "table limit readback", v, m_lim);
    for (int i = 0; i < 16; i++) begin
      poke32((m_base + i * 8) & 32'h7FFF_FFFF, 32'h0010_0000 + i * 32'h3000);
      poke32(((m_base + i * 8) & 32'h7FFF_FFFF) + 4, 32'hDEAD_0000 + i);
    end
    // R7 R10 memory-to-device across a page boundary, clamped by length
    set_ch(1, 32'h3, 32'd20, 32'h0000_0FF8);
    check_regs("R2");
    run_req(1, 1'b1, 16'd16, "R7");
    // R5 device-to-memory clamped by count
    set_ch(2, 32'h1, 32'd5, 32'h0000_2004);
    run_req(2, 1'b0, 16'd10, "R5");
    // R4 disabled channel
    set_ch(0, 32'h0, 32'd8, 32'h0);
    run_req(0, 1'b1, 16'd8, "R4");
    // R3 R4 direction mismatch clears the earlier terminal-count flag
    run_req(1, 1'b0, 16'd4, "R3");
    // R8 table limit reached mid-transfer
    set_ch(3, 32'h3, 32'd100, 32'h0000_FFFA);
    run_req(3, 1'b1, 16'd20, "R8");
    // R9 zero length, also clears the earlier memory-error flag
    run_req(1, 1'b1, 16'd0, "R9");
    // R11 R12 stray request and register write while busy
    set_ch(0, 32'h3, 32'd8, 32'h0);
    set_ch(2, 32'h1, 32'd40, 32'h0000_3000);
    d0 = done_cnt;
    start_req(2, 1'b0, 16'd30);
    @(negedge clk); req_valid = 1; req_ch = 2'd0; req_to_dev = 1'b1; req_len = 16'd4;
    @(negedge clk); req_valid = 0;
    reg_write(5'h01, 32'h55);
    reg_write(5'h11, 32'd8);
    chk(busy == 1, "R12", "still busy during stray stimulus", 32'(busy), 1);
    finish_req(d0, "R12");
    reg_read(5'h11, v); chk(v == m_lim, "R12", "limit after busy write", v, m_lim);
    // R6 R7 long transfer through three pages
    set_ch(1, 32'h3, 32'd9000, 32'h0000_6F00);
    run_req(1, 1'b1, 16'd5000, "R6");
    // R10 read back bytes written by the earlier device-to-memory run
    set_ch(2, 32'h3, 32'd7, 32'h0000_2003);
    run_req(2, 1'b1, 16'd7, "R10");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule